// File: doc/BRIEF.md
# Programmable Down-Counter Channel

This block is a single channel of a counter/timer peripheral that sits on an 8-bit I/O bus. Software sets it up with a control byte followed by a time constant. Once it is started, an 8-bit down-counter decrements on one of two kinds of tick:

- in timer mode, a tick is the system clock divided by 16 or by 256;
- in counter mode, a tick is an active edge on the external clock/trigger pin.

In timer mode the channel can also be held back until an active edge appears on that pin.

Each time the count reaches zero, the channel does three things:

- it pulses its zero-count output for one clock;
- it sets a pending interrupt flag, if interrupts are enabled;
- it reloads the stored time constant and keeps running.

The zero-count pulse is long enough to feed the clock/trigger pin of another channel, so channels can be cascaded. A bus read of the channel returns the live count. A separate acknowledge input clears the pending flag.

Top module: `ctc_channel`

## Requirements
- R1: A bus write is taken once per falling edge of `wr_ni` while `ce_ni` and `iorq_ni` are low and `chan_sel_i` equals `CHAN_ID`. A byte with bit 0 = 0 that is not an awaited time constant has no effect. Writes to another channel address have no effect.
- R2: A byte with bit 0 = 1 is a control word. Its bits are:
  - bit 7: interrupt enable;
  - bit 6: counter mode (1) or timer mode (0);
  - bit 5: divide by 256 (1) or 16 (0);
  - bit 4: rising (1) or falling (0) active edge;
  - bit 3: wait for a trigger;
  - bit 2: a time constant follows;
  - bit 1: software reset.
- R3: The byte written after a control word with bit 2 set is the time constant, whatever its bit 0. A time constant of 0 gives a period of 256 ticks.
- R4: In timer mode, the first tick comes a full prescale period (16 or 256 clocks) after the count is started, and further ticks follow at that period.
- R5: In counter mode, each active edge of `clktrg_i` decrements the count. The new value is visible three clocks after the pin changes, through a two-flop synchronizer.
- R6: When a tick takes the count to 0, the counter reloads the time constant on that same edge. `zcto_o` is then high for exactly one clock.
- R7: `irq_o` rises together with a `zcto_o` pulse when interrupt enable is set. It stays high until a clock with `irq_ack_i` high. A new terminal count wins over an acknowledge in the same clock.
- R8: In timer mode with the trigger bit set, loading the time constant does not start counting. An active edge on `clktrg_i` starts the prescaler from zero.
- R9: A software reset stops the count and holds its value. Counting restarts only when a new time constant is written, and the count starts from that value.
- R10: A time constant written while the channel is running leaves the current count alone. The new value is used at the next reload.
- R11: During a selected read (`rd_ni` low), `data_o` carries the current count and `data_oe_o` is high. Otherwise both are 0.
- R12: After reset the count is 0, the channel is stopped, and `zcto_o` and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| iorq_ni | input | 1 | I/O request, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| chan_sel_i | input | 2 | Channel address |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data (current count) |
| data_oe_o | output | 1 | Read data valid / bus drive enable |
| clktrg_i | input | 1 | External clock or trigger pin |
| zcto_o | output | 1 | Zero-count pulse |
| irq_o | output | 1 | Pending interrupt request |
| irq_ack_i | input | 1 | Clears the pending request |

## Verification
The bench covers the following corner cases:

- **Time constant of zero.** It checks that the counter wraps through 255. A design that treated 0 literally would stall or pulse on every tick.
- **Trigger hold.** It checks the hold-off before the trigger edge. A design that started on the load would show the count falling early.
- **Software reset freeze.** It checks that the count stays frozen. A design that kept counting would change the read-back value.
- **Rewrite while running.** It checks that a rewritten time constant waits for the next reload. A design that loaded it at once would break the period on the spot.
- **Edge polarity.** It switches the active edge between rising and falling. A design that ignored the polarity bit would count on the wrong pin transitions.
- **Cascade rate.** It drives random pin toggles at up to one edge every two clocks. A design with a wrong synchronizer depth or wrong edge handling would lose or double ticks.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
  localparam int unsigned BUS_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } ctc_state_e;

  // field order matches the control byte, MSB first
  typedef struct packed {
    logic irq_en;
    logic cnt_mode;
    logic presc_hi;
    logic rise_edge;
    logic trig_start;
    logic tc_next;
    logic sw_rst;
    logic is_ctrl;
  } ctc_cword_t;
endpackage

// File: rtl/ctc_bus_port.sv
module ctc_bus_port #(
  parameter logic [1:0] CHAN_ID = 2'd0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_ni,
  input  logic       iorq_ni,
  input  logic       rd_ni,
  input  logic       wr_ni,
  input  logic [1:0] chan_sel_i,
  output logic       wr_stb_o,
  output logic       rd_en_o
);
  logic sel;
  logic wr_q;

  assign sel = !ce_ni && !iorq_ni && (chan_sel_i == CHAN_ID);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b1;
    else         wr_q <= wr_ni;
  end

  // one strobe per falling edge of the write line
  assign wr_stb_o = sel && !wr_ni && wr_q;
  assign rd_en_o  = sel && !rd_ni;
endmodule

// File: rtl/ctc_edge_det.sv
module ctc_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rise_i,
  output logic edge_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q[0] <= pin_i;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[LAST];
    end
  end

  assign edge_o = rise_i ? (sync_q[LAST] & ~prev_q) : (~sync_q[LAST] & prev_q);
endmodule

// File: rtl/ctc_prescaler.sv
module ctc_prescaler #(
  parameter int unsigned DIV_LO = 16,
  parameter int unsigned DIV_HI = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic hi_i,
  output logic tick_o
);
  localparam int unsigned PW = (DIV_HI > 2) ? $clog2(DIV_HI) : 1;
  localparam logic [PW-1:0] LAST_LO = PW'(DIV_LO - 1);
  localparam logic [PW-1:0] LAST_HI = PW'(DIV_HI - 1);

  logic [PW-1:0] div_q;
  logic [PW-1:0] last;
  logic          wrap;

  assign last   = hi_i ? LAST_HI : LAST_LO;
  assign wrap   = (div_q == last);
  assign tick_o = en_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= '0;
    else if (clr_i) div_q <= '0;
    else if (en_i)  div_q <= wrap ? '0 : div_q + 1'b1;
  end
endmodule

// File: rtl/ctc_ctrl.sv
module ctc_ctrl
  import ctc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_stb_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             edge_i,
  output logic             irq_en_o,
  output logic             cnt_mode_o,
  output logic             presc_hi_o,
  output logic             rise_o,
  output logic [BUS_W-1:0] tc_o,
  output logic             tc_load_o,
  output logic             presc_clr_o,
  output ctc_state_e       state_o
);
  ctc_cword_t cw;
  ctc_state_e state_q;
  logic       expect_q;
  logic       irq_en_q, cnt_mode_q, presc_hi_q, rise_q, trig_q;
  logic [BUS_W-1:0] tc_q;
  logic       trig_go;

  assign cw          = ctc_cword_t'(wdata_i);
  assign tc_load_o   = wr_stb_i && expect_q && (state_q == ST_IDLE);
  assign trig_go     = !wr_stb_i && (state_q == ST_WAIT) && edge_i;
  assign presc_clr_o = tc_load_o || trig_go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      expect_q   <= 1'b0;
      irq_en_q   <= 1'b0;
      cnt_mode_q <= 1'b0;
      presc_hi_q <= 1'b0;
      rise_q     <= 1'b0;
      trig_q     <= 1'b0;
      tc_q       <= '0;
    end else if (wr_stb_i) begin
      if (expect_q) begin
        tc_q     <= wdata_i;
        expect_q <= 1'b0;
        if (state_q == ST_IDLE)
          state_q <= (!cnt_mode_q && trig_q) ? ST_WAIT : ST_RUN;
      end else if (cw.is_ctrl) begin
        irq_en_q   <= cw.irq_en;
        cnt_mode_q <= cw.cnt_mode;
        presc_hi_q <= cw.presc_hi;
        rise_q     <= cw.rise_edge;
        trig_q     <= cw.trig_start;
        expect_q   <= cw.tc_next;
        if (cw.sw_rst) state_q <= ST_IDLE;
      end
    end else if (trig_go) begin
      state_q <= ST_RUN;
    end
  end

  assign irq_en_o   = irq_en_q;
  assign cnt_mode_o = cnt_mode_q;
  assign presc_hi_o = presc_hi_q;
  assign rise_o     = rise_q;
  assign tc_o       = tc_q;
  assign state_o    = state_q;
endmodule

// File: rtl/ctc_downcnt.sv
module ctc_downcnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] reload_i,
  input  logic         irq_en_i,
  input  logic         irq_ack_i,
  output logic [W-1:0] cnt_o,
  output logic         zc_o,
  output logic         irq_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] dec;
  logic         hit;
  logic         zc_q;
  logic         pend_q;

  assign dec = cnt_q - 1'b1;
  assign hit = tick_i && (dec == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      zc_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      zc_q <= hit;
      if (load_i)      cnt_q <= load_val_i;
      else if (tick_i) cnt_q <= hit ? reload_i : dec;
      if (hit && irq_en_i) pend_q <= 1'b1;
      else if (irq_ack_i)  pend_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign zc_o  = zc_q;
  assign irq_o = pend_q;
endmodule

// File: rtl/ctc_channel.sv
module ctc_channel
  import ctc_pkg::*;
#(
  parameter logic [1:0]  CHAN_ID     = 2'd0,
  parameter int unsigned DIV_LO      = 16,
  parameter int unsigned DIV_HI      = 256,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_ni,
  input  logic             iorq_ni,
  input  logic             rd_ni,
  input  logic             wr_ni,
  input  logic [1:0]       chan_sel_i,
  input  logic [BUS_W-1:0] data_i,
  output logic [BUS_W-1:0] data_o,
  output logic             data_oe_o,
  input  logic             clktrg_i,
  output logic             zcto_o,
  output logic             irq_o,
  input  logic             irq_ack_i
);
  logic             wr_stb, rd_en;
  logic             pin_edge, presc_tick, tick;
  logic             irq_en, cnt_mode, presc_hi, rise;
  logic             tc_load, presc_clr, running;
  logic [BUS_W-1:0] tc_q, cnt_q;
  ctc_state_e       state_q;

  ctc_bus_port #(.CHAN_ID(CHAN_ID)) u_bus (
    .clk_i, .rst_ni, .ce_ni, .iorq_ni, .rd_ni, .wr_ni, .chan_sel_i,
    .wr_stb_o(wr_stb), .rd_en_o(rd_en)
  );

  ctc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i, .rst_ni, .pin_i(clktrg_i), .rise_i(rise), .edge_o(pin_edge)
  );

  ctc_ctrl u_ctrl (
    .clk_i, .rst_ni, .wr_stb_i(wr_stb), .wdata_i(data_i), .edge_i(pin_edge),
    .irq_en_o(irq_en), .cnt_mode_o(cnt_mode), .presc_hi_o(presc_hi),
    .rise_o(rise), .tc_o(tc_q), .tc_load_o(tc_load),
    .presc_clr_o(presc_clr), .state_o(state_q)
  );

  assign running = (state_q == ST_RUN);

  ctc_prescaler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_presc (
    .clk_i, .rst_ni, .clr_i(presc_clr), .en_i(running && !cnt_mode),
    .hi_i(presc_hi), .tick_o(presc_tick)
  );

  assign tick = running && (cnt_mode ? pin_edge : presc_tick);

  ctc_downcnt #(.W(BUS_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .load_i(tc_load), .load_val_i(data_i),
    .reload_i(tc_q), .irq_en_i(irq_en), .irq_ack_i,
    .cnt_o(cnt_q), .zc_o(zcto_o), .irq_o
  );

  assign data_oe_o = rd_en;
  assign data_o    = rd_en ? cnt_q : '0;
endmodule

// File: rtl/ctc_channel_chk.sv
module ctc_channel_chk
  import ctc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             zcto_o,
  input logic             irq_o,
  input logic             irq_ack_i,
  input logic             data_oe_o,
  input logic [BUS_W-1:0] data_o,
  input logic [BUS_W-1:0] cnt_q,
  input logic [BUS_W-1:0] tc_q,
  input ctc_state_e       state_q,
  input logic             tc_load
);
  p_zc_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zcto_o |=> !zcto_o);

  p_reload_value_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zcto_o |-> (cnt_q == $past(tc_q)));

  p_irq_source_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> zcto_o);

  p_irq_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i) |=> irq_o);

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !tc_load) |=> $stable(cnt_q));

  p_wait_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |=> $stable(cnt_q));

  p_bus_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0));
endmodule

bind ctc_channel ctc_channel_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .zcto_o(zcto_o), .irq_o(irq_o),
  .irq_ack_i(irq_ack_i), .data_oe_o(data_oe_o), .data_o(data_o),
  .cnt_q(cnt_q), .tc_q(tc_q), .state_q(state_q), .tc_load(tc_load)
);

// File: tb/ctc_channel_tb.sv
`timescale 1ns/1ps
module ctc_channel_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] chan = 2'd0;
  logic [7:0] din = 8'h00;
  logic [7:0] data_o;
  logic       data_oe;
  logic       clktrg = 1'b0;
  logic       zcto, irq, ack = 1'b0;

  int    n_checks = 0;
  int    n_fail = 0;
  string cur_req = "R12";

  always #2 clk = ~clk;

  ctc_channel u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .iorq_ni(iorq_n),
    .rd_ni(rd_n), .wr_ni(wr_n), .chan_sel_i(chan), .data_i(din),
    .data_o(data_o), .data_oe_o(data_oe), .clktrg_i(clktrg),
    .zcto_o(zcto), .irq_o(irq), .irq_ack_i(ack)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: state held as integers, pin history as a queue
  int m_cfg, m_tc, m_cnt, m_state, m_p, m_exp;
  bit m_zc, m_irq, m_wrp;
  bit hist[$];
  int o_cfg, o_state, o_exp, lastp, nxt;
  bit sel, wr, edg, tick, hit, clr, cm, tr, rise, exp_oe;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 0; m_tc = 0; m_cnt = 0; m_state = 0; m_p = 0; m_exp = 0;
      m_zc = 0; m_irq = 0; m_wrp = 1;
      hist = '{0, 0, 0};
    end else begin
      o_cfg = m_cfg; o_state = m_state; o_exp = m_exp;
      sel = !ce_n && !iorq_n && (chan == 2'd0);
      wr = sel && !wr_n && m_wrp;
      m_wrp = wr_n;
      rise = o_cfg[4];
      cm = o_cfg[6];
      tr = o_cfg[3];
      edg = rise ? (hist[1] && !hist[2]) : (!hist[1] && hist[2]);
      hist.push_front(clktrg);
      void'(hist.pop_back());
      lastp = o_cfg[5] ? 255 : 15;
      tick = (o_state == 2) && (cm ? edg : (m_p == lastp));
      hit = 0;
      if (tick) begin
        nxt = (m_cnt + 255) % 256;
        if (nxt == 0) begin hit = 1; m_cnt = m_tc; end
        else m_cnt = nxt;
      end
      m_zc = hit;
      if (hit && o_cfg[7]) m_irq = 1;
      else if (ack) m_irq = 0;
      clr = 0;
      if (wr) begin
        if (o_exp != 0) begin
          m_tc = din; m_exp = 0;
          if (o_state == 0) begin
            m_cnt = din; clr = 1;
            m_state = (!cm && tr) ? 1 : 2;
          end
        end else if (din[0]) begin
          m_cfg = din; m_exp = din[2];
          if (din[1]) m_state = 0;
        end
      end else if (o_state == 1 && edg) begin
        m_state = 2; clr = 1;
      end
      if (clr) m_p = 0;
      else if (o_state == 2 && !cm) m_p = (m_p == lastp) ? 0 : (m_p + 1) % 256;
    end
    #1;
    exp_oe = !ce_n && !iorq_n && (chan == 2'd0) && !rd_n;
    check("R6", zcto, m_zc);
    check("R7", irq, m_irq);
    check("R11", data_oe, exp_oe);
    if (exp_oe) check(cur_req, data_o, m_cnt);
    else        check("R11", data_o, 0);
  end

  task automatic bus_wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    ce_n = 0; iorq_n = 0; wr_n = 0; chan = s; din = d;
    @(negedge clk);
    ce_n = 1; iorq_n = 1; wr_n = 1; chan = 0;
  endtask

  task automatic bus_rd(input logic [1:0] s, output logic [7:0] v, output logic oe);
    @(negedge clk);
    ce_n = 0; iorq_n = 0; rd_n = 0; chan = s;
    @(posedge clk);
    #1;
    v = data_o; oe = data_oe;
    @(negedge clk);
    ce_n = 1; iorq_n = 1; rd_n = 1; chan = 0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); clktrg = ~clktrg;
      @(negedge clk);
      @(negedge clk); clktrg = ~clktrg;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ack_irq();
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  logic [7:0] v, v2;
  logic       oe;

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;

    // R12: reset state
    cur_req = "R12";
    bus_rd(2'd0, v, oe);
    check("R12", v, 0);
    check("R12", zcto, 0);
    check("R12", irq, 0);

    // R1: other channel address and stray data bytes are ignored
    cur_req = "R1";
    bus_wr(2'd2, 8'h85);
    bus_wr(2'd2, 8'h05);
    idle(40);
    bus_rd(2'd0, v, oe);
    check("R1", v, 0);
    bus_wr(2'd0, 8'h40);
    idle(40);
    bus_rd(2'd0, v, oe);
    check("R1", v, 0);

    // R4: timer divide-by-16, time constant 3
    cur_req = "R4";
    bus_wr(2'd0, 8'h85);
    bus_wr(2'd0, 8'h03);
    bus_rd(2'd0, v, oe);
    check("R4", v, 3);
    idle(20);
    bus_rd(2'd0, v, oe);
    check("R4", v, 2);
    for (int i = 0; i < 12; i++) begin idle(11); bus_rd(2'd0, v, oe); end
    check("R7", irq, 1);
    ack_irq();
    idle(3);
    check("R7", irq, 0);

    // R2: divide-by-256 via control bit 5
    cur_req = "R2";
    bus_wr(2'd0, 8'hA7);
    bus_wr(2'd0, 8'h02);
    bus_rd(2'd0, v, oe);
    check("R2", v, 2);
    for (int i = 0; i < 20; i++) begin idle(35); bus_rd(2'd0, v, oe); end

    // R10: rewrite while running waits for the reload
    cur_req = "R10";
    bus_wr(2'd0, 8'h85);
    bus_wr(2'd0, 8'h05);
    bus_rd(2'd0, v, oe);
    check("R10", (v <= 2) ? 1 : 0, 1);
    for (int i = 0; i < 40; i++) begin idle(23); bus_rd(2'd0, v, oe); end
    ack_irq();

    // R9: software reset freezes the count
    cur_req = "R9";
    bus_wr(2'd0, 8'h03);
    bus_rd(2'd0, v, oe);
    idle(100);
    bus_rd(2'd0, v2, oe);
    check("R9", v2, v);
    bus_wr(2'd0, 8'h85);
    bus_wr(2'd0, 8'h04);
    bus_rd(2'd0, v, oe);
    check("R9", v, 4);
    idle(150);
    ack_irq();

    // R3: counter mode, rising edge, time constant 0 = 256
    cur_req = "R3";
    bus_wr(2'd0, 8'hD7);
    bus_wr(2'd0, 8'h00);
    pulses(1);
    idle(6);
    bus_rd(2'd0, v, oe);
    check("R3", v, 255);
    pulses(300);
    idle(6);
    bus_rd(2'd0, v, oe);
    check("R3", v, 211);
    ack_irq();

    // R5: counter mode, falling edge, time constant 4
    cur_req = "R5";
    bus_wr(2'd0, 8'hC7);
    bus_wr(2'd0, 8'h04);
    pulses(10);
    idle(6);
    bus_rd(2'd0, v, oe);
    check("R5", v, 2);
    ack_irq();

    // R8: triggered timer start
    cur_req = "R8";
    bus_wr(2'd0, 8'h9F);
    bus_wr(2'd0, 8'h04);
    idle(50);
    bus_rd(2'd0, v, oe);
    check("R8", v, 4);
    @(negedge clk); clktrg = 1;
    idle(9);
    bus_rd(2'd0, v, oe);
    check("R8", v, 4);
    idle(30);
    bus_rd(2'd0, v, oe);
    check("R8", v, 2);
    @(negedge clk); clktrg = 0;
    idle(100);

    // R11: read of another channel address leaves the bus quiet
    cur_req = "R11";
    bus_rd(2'd1, v, oe);
    check("R11", oe, 0);
    check("R11", v, 0);

    // R5: random pin activity, chained-rate edges
    cur_req = "R5";
    bus_wr(2'd0, 8'hD7);
    bus_wr(2'd0, 8'h01);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom_range(2) == 0) clktrg = ~clktrg;
      if (i % 50 == 0) bus_rd(2'd0, v, oe);
      if (i % 97 == 0) ack_irq();
    end
    bus_wr(2'd0, 8'hC7);
    bus_wr(2'd0, 8'h03);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if ($urandom_range(3) == 0) clktrg = ~clktrg;
      if (i % 41 == 0) bus_rd(2'd0, v, oe);
      if (i % 131 == 0) ack_irq();
    end

    idle(10);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule